// File: doc/BRIEF.md
# Reversible Gate Cascade Engine

This block keeps a short program of reversible gates and applies it to an 8-wire binary register, one program slot per clock. A slot holds one of four three-wire gate kinds: a controlled-NOT, a doubly controlled NOT, a controlled swap, and a non-linear three-wire permutation gate (the "K" gate). The first three are their own inverses. The K gate is not, so the engine keeps its inverse mapping for backward runs.

A run starts from an idle engine. It latches the wire register and executes the whole program either forward (slot 0 upward) or backward (last slot downward). A backward run gives the inverse function of the cascade. A third mode does the copy-and-uncompute sequence: a forward pass, then a single copy step, then a backward pass. The copy step XORs the selected lower-half wires into the matching upper-half ancilla wires, which start at zero. At the end the lower half holds the original inputs again and the ancillas hold the copied results, so no garbage is left. A one-cycle done pulse marks the end of every run. A sticky error flag reports any gate whose operand indices collide.

Top module: `rev_cascade_engine`

## Requirements
- R1: A controlled-NOT slot leaves wire `a` unchanged and replaces wire `b` with `a XOR b`.
- R2: A doubly controlled NOT slot leaves wires `a` and `b` unchanged and replaces wire `c` with `(a AND b) XOR c`.
- R3: A controlled-swap slot uses wire `c` as its control, and `c` itself is unchanged. Wires `a` and `b` are exchanged when `c`=1 and kept when `c`=0.
- R4: A K slot run forward writes P to wire `a`, Q to wire `b` and R to wire `c`, where P = 1^A^B^C^AB, Q = 1^AB^B^C^BC and R = 1^A^B^AC. With C=1 these give P = A|B, Q = A&B and R = ~B.
- R5: A backward run visits slots from the highest index down to 0. Each gate applies its inverse, and the K gate uses the inverse of the R4 mapping. A forward run followed by a backward run on the result therefore returns every wire to its start value.
- R6: In clean mode (`clean_i`=1, `dir_i` ignored) the engine runs a forward pass, then one copy cycle, then a backward pass. In the copy cycle, wire i+4 ^= wire i for every i with `copy_mask_i[i]`=1. The final lower half equals the input lower half, and upper wire i+4 equals its input XOR the forward result of wire i.
- R7: If a slot's operand indices collide (a==b for the controlled-NOT; any equal pair among a, b, c for the other kinds), the register is left unchanged for that slot and `err_o` goes to 1. `err_o` stays set until the next accepted start, which clears it.
- R8: A slot whose valid bit is 0 leaves the register unchanged. Program writes and start requests made while a run is in progress are ignored.
- R9: `done_o` is high for exactly one cycle. For a plain run it is first seen 16 cycles after the clock edge that accepted the start; for a clean run it is first seen after 33 cycles.
- R10: A slot word is 12 bits: bit 11 is the valid bit, bits 10:9 the kind (0 controlled-NOT, 1 doubly controlled NOT, 2 controlled swap, 3 K gate), and bits 8:6, 5:3 and 2:0 the wire indices a, b and c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_we_i | input | 1 | Program slot write strobe (idle only) |
| ld_addr_i | input | 4 | Program slot index |
| ld_data_i | input | 12 | Program slot word |
| start_i | input | 1 | Start request (idle only) |
| dir_i | input | 1 | 0 forward, 1 backward |
| clean_i | input | 1 | Selects the copy-and-uncompute sequence |
| copy_mask_i | input | 4 | Lower-half wires copied to ancillas in clean mode |
| wires_i | input | 8 | Register value latched at start |
| wires_o | output | 8 | Current register value |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky operand collision flag |

## Verification
The gate checks assume a program stays fixed during a run, so the bench loads slots only while the engine is idle. The single exception is one deliberate busy-time write, used to show that it is ignored. The K inverse check and the controlled-swap ones-count check assume the slot's operand indices are distinct. The random programs are therefore built with distinct indices, and collisions are produced only in the directed error test. Clean mode assumes the ancilla wires start at zero and that the program touches only the lower half, so the clean-mode tests use programs and inputs that keep to this.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  typedef enum logic [1:0] {
    G_CNOT  = 2'd0,
    G_CCNOT = 2'd1,
    G_CSWAP = 2'd2,
    G_KGATE = 2'd3
  } gate_e;

  // abc = {A,B,C}; result = {P,Q,R}
  function automatic logic [2:0] kg_fwd(input logic [2:0] abc);
    logic x, y, z;
    x = abc[2]; y = abc[1]; z = abc[0];
    return {1'b1 ^ x ^ y ^ z ^ (x & y),
            1'b1 ^ (x & y) ^ y ^ z ^ (y & z),
            1'b1 ^ x ^ y ^ (x & z)};
  endfunction

  function automatic logic [2:0] kg_inv(input logic [2:0] pqr);
    logic [2:0] r;
    r = '0;
    for (int k = 0; k < 8; k++)
      if (kg_fwd(3'(k)) == pqr) r = 3'(k);
    return r;
  endfunction
endpackage

// File: rtl/rgc_gate_store.sv
module rgc_gate_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rgc_gate_unit.sv
module rgc_gate_unit
  import rgc_pkg::*;
#(
  parameter int NW     = 8,
  localparam int IW    = $clog2(NW),
  localparam int EW    = 3 + 3 * IW
) (
  input  logic [EW-1:0] entry_i,
  input  logic          rev_i,
  input  logic [NW-1:0] wires_i,
  output logic [NW-1:0] wires_o,
  output logic          dup_o
);
  logic          vld;
  gate_e         kind;
  logic [IW-1:0] ia, ib, ic;
  logic          dup;
  logic [2:0]    kin, kout;

  assign vld  = entry_i[EW-1];
  assign kind = gate_e'(entry_i[EW-2 -: 2]);
  assign ia   = entry_i[3*IW-1 -: IW];
  assign ib   = entry_i[2*IW-1 -: IW];
  assign ic   = entry_i[IW-1:0];

  assign dup   = (ia == ib) || ((kind != G_CNOT) && ((ia == ic) || (ib == ic)));
  assign dup_o = vld && dup;

  assign kin  = {wires_i[ia], wires_i[ib], wires_i[ic]};
  assign kout = rev_i ? kg_inv(kin) : kg_fwd(kin);

  always_comb begin
    wires_o = wires_i;
    if (vld && !dup) begin
      unique case (kind)
        G_CNOT:  wires_o[ib] = wires_i[ib] ^ wires_i[ia];
        G_CCNOT: wires_o[ic] = wires_i[ic] ^ (wires_i[ia] & wires_i[ib]);
        G_CSWAP: if (wires_i[ic]) begin
                   wires_o[ia] = wires_i[ib];
                   wires_o[ib] = wires_i[ia];
                 end
        G_KGATE: begin
                   wires_o[ia] = kout[2];
                   wires_o[ib] = kout[1];
                   wires_o[ic] = kout[0];
                 end
        default: wires_o = wires_i;
      endcase
    end
  end

  always_comb begin
    if (vld && !dup && kind == G_CSWAP)
      AST_CSWAP_CONSERVE: assert ($countones(wires_o) == $countones(wires_i)); // R3
    if (vld && !dup && kind == G_KGATE && rev_i)
      AST_KGATE_INVERSE: assert (kg_fwd({wires_o[ia], wires_o[ib], wires_o[ic]}) == kin); // R5
  end
endmodule

// File: rtl/rgc_seq.sv
module rgc_seq #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_i,
  input  logic          clean_i,
  output logic [AW-1:0] ptr_o,
  output logic          rev_o,
  output logic          idle_o,
  output logic          load_o,
  output logic          run_o,
  output logic          copy_o,
  output logic          done_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_COPY, S_DONE} state_e;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  state_e        st_q;
  logic [AW-1:0] ptr_q;
  logic          rev_q, clean_q;
  logic          first_rev;

  assign first_rev = !clean_i && dir_i;
  assign idle_o = (st_q == S_IDLE);
  assign load_o = idle_o && start_i;
  assign run_o  = (st_q == S_RUN);
  assign copy_o = (st_q == S_COPY);
  assign done_o = (st_q == S_DONE);
  assign ptr_o  = ptr_q;
  assign rev_o  = rev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      ptr_q   <= '0;
      rev_q   <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q    <= S_RUN;
          rev_q   <= first_rev;
          ptr_q   <= first_rev ? LAST : '0;
          clean_q <= clean_i;
        end
        S_RUN: begin
          if (ptr_q == (rev_q ? '0 : LAST))
            st_q <= (clean_q && !rev_q) ? S_COPY : S_DONE;
          else
            ptr_q <= rev_q ? ptr_q - 1'b1 : ptr_q + 1'b1;
        end
        S_COPY: begin
          st_q  <= S_RUN;
          rev_q <= 1'b1;
          ptr_q <= LAST;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_COPY_THEN_REV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_o |=> (run_o && rev_o && ptr_o == LAST)); // R6
endmodule

// File: rtl/rev_cascade_engine.sv
module rev_cascade_engine #(
  parameter int NW     = 8,
  parameter int DEPTH  = 16,
  localparam int IW    = $clog2(NW),
  localparam int AW    = $clog2(DEPTH),
  localparam int EW    = 3 + 3 * IW,
  localparam int HALF  = NW / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_we_i,
  input  logic [AW-1:0]   ld_addr_i,
  input  logic [EW-1:0]   ld_data_i,
  input  logic            start_i,
  input  logic            dir_i,
  input  logic            clean_i,
  input  logic [HALF-1:0] copy_mask_i,
  input  logic [NW-1:0]   wires_i,
  output logic [NW-1:0]   wires_o,
  output logic            done_o,
  output logic            err_o
);
  logic [AW-1:0]   ptr;
  logic            rev, idle, load, run, copy;
  logic [EW-1:0]   entry;
  logic [NW-1:0]   wq, gate_out;
  logic            dup;
  logic [HALF-1:0] mask_q;
  logic            err_q;

  rgc_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i, .rst_ni, .start_i, .dir_i, .clean_i,
    .ptr_o(ptr), .rev_o(rev), .idle_o(idle), .load_o(load),
    .run_o(run), .copy_o(copy), .done_o(done_o)
  );

  rgc_gate_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk_i, .rst_ni,
    .we_i(ld_we_i && idle), .waddr_i(ld_addr_i), .wdata_i(ld_data_i),
    .raddr_i(ptr), .rdata_o(entry)
  );

  rgc_gate_unit #(.NW(NW)) u_gate (
    .entry_i(entry), .rev_i(rev), .wires_i(wq),
    .wires_o(gate_out), .dup_o(dup)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wq     <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else if (load) begin
      wq     <= wires_i;
      mask_q <= copy_mask_i;
      err_q  <= 1'b0;
    end else if (run) begin
      wq <= gate_out;
      if (dup) err_q <= 1'b1;
    end else if (copy) begin
      wq[NW-1:HALF] <= wq[NW-1:HALF] ^ (wq[HALF-1:0] & mask_q);
    end
  end

  assign wires_o = wq;
  assign err_o   = err_q;

  AST_ERR_KEEPS_WIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $stable(wq)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !start_i) |=> $stable(wq)); // R8
  AST_COPY_KEEPS_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy |=> $stable(wq[HALF-1:0])); // R6
endmodule

// File: tb/rev_cascade_engine_bench.sv
module rev_cascade_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_we_i = 1'b0;
  logic [3:0]  ld_addr_i = '0;
  logic [11:0] ld_data_i = '0;
  logic        start_i = 1'b0, dir_i = 1'b0, clean_i = 1'b0;
  logic [3:0]  copy_mask_i = '0;
  logic [7:0]  wires_i = '0;
  logic [7:0]  wires_o;
  logic        done_o, err_o;

  int errors = 0;
  int checks = 0;
  logic [11:0] prog [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rev_cascade_engine u_rev_cascade_engine (
    .clk_i(clk), .rst_ni, .ld_we_i, .ld_addr_i, .ld_data_i, .start_i,
    .dir_i, .clean_i, .copy_mask_i, .wires_i, .wires_o, .done_o, .err_o
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10 slot word
  function automatic logic [11:0] ent(input int t, input int a, input int b, input int c);
    return {1'b1, 2'(t), 3'(a), 3'(b), 3'(c)};
  endfunction

  function automatic logic [2:0] kf(input logic [2:0] v);
    logic x, y, z;
    x = v[2]; y = v[1]; z = v[0];
    return {~(x ^ y ^ z ^ (x & y)), ~((x & y) ^ y ^ z ^ (y & z)), ~(x ^ y ^ (x & z))};
  endfunction

  function automatic logic [7:0] m_gate(input logic [7:0] w, input logic [11:0] e, input logic rev);
    logic [7:0] r;
    int a, b, c;
    logic [2:0] k;
    r = w; a = e[8:6]; b = e[5:3]; c = e[2:0];
    if (!e[11]) return w;
    if (a == b) return w;
    if (e[10:9] != 0 && (a == c || b == c)) return w;
    case (e[10:9])
      2'd0: r[b] = w[a] ^ w[b];
      2'd1: r[c] = w[c] ^ (w[a] & w[b]);
      2'd2: if (w[c]) begin r[a] = w[b]; r[b] = w[a]; end
      default: begin
        k = kf({w[a], w[b], w[c]});
        if (rev)
          for (int q = 0; q < 8; q++) if (kf(3'(q)) == {w[a], w[b], w[c]}) k = 3'(q);
        r[a] = k[2]; r[b] = k[1]; r[c] = k[0];
      end
    endcase
    return r;
  endfunction

  function automatic logic [7:0] m_pass(input logic [7:0] w, input logic rev);
    logic [7:0] r;
    r = w;
    for (int i = 0; i < 16; i++) r = m_gate(r, prog[rev ? 15 - i : i], rev);
    return r;
  endfunction

  task automatic load_prog();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ld_we_i = 1'b1; ld_addr_i = 4'(i); ld_data_i = prog[i];
    end
    @(negedge clk);
    ld_we_i = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = '0;
  endtask

  task automatic run(input logic [7:0] w, input logic d, input logic cl, input logic [3:0] m,
                     output logic [7:0] res, output int cyc);
    @(negedge clk);
    wires_i = w; dir_i = d; clean_i = cl; copy_mask_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    res = wires_o;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] res, w0, exp, lo;
    int cyc;
    repeat (3) @(negedge clk);
    chk(wires_o == 0 && !done_o && !err_o, "reset", {wires_o, done_o, err_o}, 0);
    rst_ni = 1'b1;

    // half adder, R1 R2 R8 R10 (slots 2..15 invalid)
    clear_prog();
    prog[0] = ent(1, 0, 1, 2);
    prog[1] = ent(0, 0, 1, 0);
    load_prog();
    for (int v = 0; v < 4; v++) begin
      w0 = 8'hF0 | 8'(v);
      run(w0, 1'b0, 1'b0, 4'h0, res, cyc);
      exp = {w0[7:3], w0[0] & w0[1], w0[0] ^ w0[1], w0[0]};
      chk(res == exp, "R1 R2 R10 half adder", res, exp);
      chk(cyc == 16, "R9 plain timing", cyc, 16);
      @(negedge clk);
      chk(!done_o, "R9 pulse width", done_o, 0);
    end

    // single-gate exhaustive sweeps on wires 2,5,7 (a,b,c)
    for (int t = 0; t < 4; t++) begin
      clear_prog();
      prog[9] = ent(t, 2, 5, 7);
      load_prog();
      for (int v = 0; v < 8; v++) begin
        w0 = 8'h19;
        w0[2] = v[2]; w0[5] = v[1]; w0[7] = v[0];
        run(w0, 1'b0, 1'b0, 4'h0, res, cyc);
        exp = m_gate(w0, prog[9], 1'b0);
        chk(res == exp, t == 0 ? "R1" : t == 1 ? "R2" : t == 2 ? "R3" : "R4", res, exp);
        if (t == 3 && v[0]) begin
          chk({res[2], res[5], res[7]} == {v[2] | v[1], v[2] & v[1], ~v[1]},
              "R4 C=1 reduction", {res[2], res[5], res[7]}, {v[2] | v[1], v[2] & v[1], ~v[1]});
        end
        if (t == 3) begin
          run(res, 1'b1, 1'b0, 4'h0, res, cyc);
          chk(res == w0, "R5 K inverse", res, w0);
        end
      end
    end

    // random programs, forward then backward, R5
    for (int n = 0; n < 24; n++) begin
      for (int i = 0; i < 16; i++) begin
        int a, b, c;
        a = $urandom_range(0, 7);
        b = (a + 1 + $urandom_range(0, 6)) % 8;
        do c = $urandom_range(0, 7); while (c == a || c == b);
        prog[i] = ent($urandom_range(0, 3), a, b, c);
        if ($urandom_range(0, 7) == 0) prog[i][11] = 1'b0;
      end
      load_prog();
      w0 = 8'($urandom);
      run(w0, 1'b0, 1'b0, 4'h0, res, cyc);
      exp = m_pass(w0, 1'b0);
      chk(res == exp, "R5 forward random", res, exp);
      run(res, 1'b1, 1'b0, 4'h0, res, cyc);
      chk(res == w0, "R5 round trip", res, w0);
      chk(!err_o, "R7 no false error", err_o, 0);
    end

    // clean mode with half adder, R6 R9
    clear_prog();
    prog[0] = ent(1, 0, 1, 2);
    prog[1] = ent(0, 0, 1, 0);
    load_prog();
    for (int v = 0; v < 4; v++) begin
      w0 = 8'h08 | 8'(v);
      run(w0, 1'b1, 1'b1, 4'b0110, res, cyc);
      exp = w0;
      exp[5] = w0[5] ^ (w0[0] ^ w0[1]);
      exp[6] = w0[6] ^ (w0[0] & w0[1]);
      chk(res == exp, "R6 clean result", res, exp);
      chk(cyc == 33, "R9 clean timing", cyc, 33);
    end

    // collision, R7
    clear_prog();
    prog[0] = ent(0, 3, 3, 0);
    prog[1] = ent(0, 0, 1, 0);
    prog[2] = ent(2, 4, 5, 4);
    load_prog();
    w0 = 8'h39;
    run(w0, 1'b0, 1'b0, 4'h0, res, cyc);
    exp = w0; exp[1] = w0[0] ^ w0[1];
    chk(res == exp, "R7 collided slot skipped", res, exp);
    chk(err_o, "R7 error raised", err_o, 1);
    @(negedge clk);
    chk(err_o, "R7 error sticky", err_o, 1);
    clear_prog();
    prog[0] = ent(0, 0, 1, 0);
    load_prog();
    run(w0, 1'b0, 1'b0, 4'h0, res, cyc);
    chk(!err_o, "R7 cleared by start", err_o, 0);

    // busy-time write and start ignored, R8
    @(negedge clk);
    wires_i = 8'h01; dir_i = 1'b0; clean_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    ld_we_i = 1'b1; ld_addr_i = 4'd0; ld_data_i = ent(0, 0, 2, 0);
    wires_i = 8'hFF; start_i = 1'b1;
    @(negedge clk);
    ld_we_i = 1'b0; start_i = 1'b0;
    cyc = 5;
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 16, "R8 start ignored while busy", cyc, 16);
    chk(wires_o == 8'h03, "R8 busy run result", wires_o, 8'h03);
    run(8'h01, 1'b0, 1'b0, 4'h0, res, cyc);
    chk(res == 8'h03, "R8 busy write ignored", res, 8'h03);
    @(negedge clk);
    lo = wires_o;
    repeat (3) @(negedge clk);
    chk(wires_o == lo, "R8 idle hold", wires_o, lo);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule